// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers up to 32 external interrupt wires into a single interrupt request for a processor. Each wire is brought into the core clock domain by a two-flop synchroniser. A per-line sense setting then decides which condition counts as an event. The setting can be a low level, a high level, a falling edge, a rising edge, or either edge.

Events set a per-line detect latch. Software clears a latch by writing a one to its bit. A per-line enable mask selects which latched events appear in the request status word. The OR of the masked vector, registered once, drives the interrupt output. Software programs and reads the block through a plain 32-bit register port: address, write enable, write data, and combinational read data.

Register words, by byte offset:

| Offset | Access | Content |
|---|---|---|
| 0x000 | read | request status: detect AND enable |
| 0x004 | read | enable mask |
| 0x004 | write | write-one-to-clear enables |
| 0x008 | write | write-one-to-set enables (reads 0) |
| 0x100 | read | detect latches |
| 0x100 | write | write-one-to-clear detect latches |
| 0x104 | read | synchronised line levels |
| 0x180 + 4·n | read/write | sense field of line n in bits [5:0] |

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every enable bit, detect latch and sense field is zero, and `irqOut` is low.
- R2: A write to offset 0x008 sets each enable bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A write to offset 0x004 clears each enable bit whose write-data bit is 1. Bits written as 0 keep their value. A read of offset 0x004 returns the enable mask.
- R4: Offset 0x180 + 4·n holds the sense field of line n in bits [5:0]. A read returns those six bits, with all higher bits zero. Accesses whose address bits [1:0] are not zero are ignored.
- R5: Sense code 0x01 detects a low level and code 0x02 detects a high level. While the line stays at its active level, its detect bit stays set, even across a clear.
- R6: Sense code 0x04 detects a falling edge, 0x08 a rising edge, and 0x0C either edge. A line held steady after its edge does not set the bit again once it is cleared.
- R7: A sense field of zero, or any value other than 0x01, 0x02, 0x04, 0x08 or 0x0C, never sets that line's detect bit.
- R8: Offset 0x100 reads the detect latches. Writing a 1 to a bit clears that latch. Bits written as 0 are left unchanged.
- R9: Offset 0x104 reads each line's level as seen after two synchroniser flops.
- R10: Offset 0x000 reads the detect latches ANDed with the enable mask. `irqOut` equals the OR of that vector one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rstN | input | 1 | asynchronous active-low reset |
| irqLines | input | NUM_LINES | external interrupt wires, asynchronous |
| busAddr | input | ADDR_W | byte address of the register access |
| busWe | input | 1 | write strobe, one write per asserted cycle |
| busWdata | input | 32 | write data |
| busRdata | output | 32 | read data for `busAddr`, same cycle |
| irqOut | output | 1 | combined registered interrupt request |

## Verification
The assertions assume the following about the inputs:
- Only one register access happens per cycle, so at most one write strobe fires at a time.
- Reset is held across at least one clock edge.

The stimulus respects this:
- It changes the bus and the interrupt wires only on falling clock edges.
- It drops the write enable after a single cycle.
- It holds every wire level for at least four cycles, so both synchroniser flops and the detect latch settle before a result is sampled.

Reads are sampled half a cycle after the edge that updates the state.

// File: rtl/eic_pkg.sv
package eic_pkg;

  localparam int MAX_LINES = 32;
  localparam int SENSE_W   = 6;
  localparam int IDX_W     = 5;

  // byte offsets of the register words
  localparam int OFF_REQ   = 'h000;
  localparam int OFF_ENCLR = 'h004;
  localparam int OFF_ENSET = 'h008;
  localparam int OFF_DET   = 'h100;
  localparam int OFF_MON   = 'h104;
  localparam int OFF_CFG0  = 'h180;

  // one-hot style sense codes
  localparam logic [SENSE_W-1:0] SENSE_LOW  = 6'h01;
  localparam logic [SENSE_W-1:0] SENSE_HIGH = 6'h02;
  localparam logic [SENSE_W-1:0] SENSE_FALL = 6'h04;
  localparam logic [SENSE_W-1:0] SENSE_RISE = 6'h08;
  localparam logic [SENSE_W-1:0] SENSE_BOTH = 6'h0C;

  // control -> datapath strobes
  typedef struct packed {
    logic                 enSet;
    logic                 enClr;
    logic                 detClr;
    logic                 cfgWr;
    logic [IDX_W-1:0]     cfgIdx;
    logic [MAX_LINES-1:0] wdata;
  } strobe_t;

  // datapath -> control read sources
  typedef struct packed {
    logic [MAX_LINES-1:0] req;
    logic [MAX_LINES-1:0] en;
    logic [MAX_LINES-1:0] det;
    logic [MAX_LINES-1:0] mon;
    logic [SENSE_W-1:0]   cfgRd;
  } status_t;

  // event for one line given its sense field, synchronised level and previous level
  function automatic logic senseEvent(input logic [SENSE_W-1:0] mode,
                                      input logic lvl, input logic prev);
    logic ev;
    case (mode)
      SENSE_LOW:  ev = ~lvl;
      SENSE_HIGH: ev = lvl;
      SENSE_FALL: ev = prev & ~lvl;
      SENSE_RISE: ev = lvl & ~prev;
      SENSE_BOTH: ev = lvl ^ prev;
      default:    ev = 1'b0;
    endcase
    return ev;
  endfunction

endpackage

// File: rtl/eic_ctrl.sv
module eic_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  input  status_t           stat,
  output strobe_t           strb,
  output logic [31:0]       busRdata
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_REQ    = WORD_W'(OFF_REQ >> 2);
  localparam logic [WORD_W-1:0] W_ENCLR  = WORD_W'(OFF_ENCLR >> 2);
  localparam logic [WORD_W-1:0] W_ENSET  = WORD_W'(OFF_ENSET >> 2);
  localparam logic [WORD_W-1:0] W_DET    = WORD_W'(OFF_DET >> 2);
  localparam logic [WORD_W-1:0] W_MON    = WORD_W'(OFF_MON >> 2);
  localparam logic [WORD_W-1:0] W_CFG0   = WORD_W'(OFF_CFG0 >> 2);
  localparam logic [WORD_W-1:0] W_CFGEND = WORD_W'((OFF_CFG0 >> 2) + NUM_LINES);

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              inCfg;

  assign word    = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign inCfg   = aligned && (word >= W_CFG0) && (word < W_CFGEND);

  always_comb begin
    strb        = '0;
    strb.wdata  = busWdata;
    strb.cfgIdx = IDX_W'(word - W_CFG0);
    strb.enSet  = busWe && aligned && (word == W_ENSET);
    strb.enClr  = busWe && aligned && (word == W_ENCLR);
    strb.detClr = busWe && aligned && (word == W_DET);
    strb.cfgWr  = busWe && inCfg;
  end

  always_comb begin
    busRdata = '0;
    if (aligned) begin
      if (word == W_REQ)        busRdata = stat.req;
      else if (word == W_ENCLR) busRdata = stat.en;
      else if (word == W_DET)   busRdata = stat.det;
      else if (word == W_MON)   busRdata = stat.mon;
      else if (inCfg)           busRdata = 32'(stat.cfgRd);
    end
  end

  // R4: a single access decodes to at most one write strobe
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.enSet, strb.enClr, strb.detClr, strb.cfgWr}));

endmodule

// File: rtl/eic_datapath.sv
module eic_datapath
  import eic_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  strobe_t              strb,
  output status_t              stat,
  output logic                 irqOut
);
  logic [NUM_LINES-1:0] syncLvl;
  logic [NUM_LINES-1:0] prevLvl;
  logic [NUM_LINES-1:0] evt;
  logic [NUM_LINES-1:0] det;
  logic [NUM_LINES-1:0] enMask;
  logic [NUM_LINES-1:0] req;
  logic [SENSE_W-1:0]   cfgArr [NUM_LINES];
  logic [NUM_LINES-1:0] wBits;

  assign wBits = strb.wdata[NUM_LINES-1:0];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [SYNC_STAGES-1:0] chain;
    logic                   prevQ;
    logic                   detQ;
    logic [SENSE_W-1:0]     cfgQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain <= '0;
        prevQ <= 1'b0;
        detQ  <= 1'b0;
        cfgQ  <= '0;
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], irqLines[i]};
        prevQ <= chain[SYNC_STAGES-1];
        // a fresh event wins over a clear in the same cycle
        detQ  <= (detQ & ~(strb.detClr & wBits[i])) | evt[i];
        if (strb.cfgWr && (int'(strb.cfgIdx) == i))
          cfgQ <= strb.wdata[SENSE_W-1:0];
      end
    end

    assign syncLvl[i] = chain[SYNC_STAGES-1];
    assign prevLvl[i] = prevQ;
    assign det[i]     = detQ;
    assign cfgArr[i]  = cfgQ;
    assign evt[i]     = senseEvent(cfgQ, chain[SYNC_STAGES-1], prevQ);

    // R7: a line with a zero sense field cannot raise its latch
    a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
      (cfgQ == '0 && !detQ) |=> !detQ);

    // R6: in rising-edge mode a new latch needs a high synchronised level
    a_r6_rise_needs_high: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(detQ) && $past(cfgQ) == SENSE_RISE) |-> $past(syncLvl[i]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask <= '0;
      irqOut <= 1'b0;
    end else begin
      if (strb.enSet) enMask <= enMask | wBits;
      else if (strb.enClr) enMask <= enMask & ~wBits;
      irqOut <= |req;
    end
  end

  assign req = det & enMask;

  always_comb begin
    stat       = '0;
    stat.req   = 32'(req);
    stat.en    = 32'(enMask);
    stat.det   = 32'(det);
    stat.mon   = 32'(syncLvl);
    stat.cfgRd = (int'(strb.cfgIdx) < NUM_LINES) ? cfgArr[strb.cfgIdx] : '0;
  end

  // R2: set strobe leaves every written-one bit enabled
  a_r2_enable_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.enSet |=> ((enMask & $past(wBits)) == $past(wBits)));

  // R3: clear strobe leaves every written-one bit disabled
  a_r3_enable_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.enClr |=> ((enMask & $past(wBits)) == '0));

  // R10: the output follows the masked requests one cycle later
  a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    (|req) |=> irqOut);
  a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rstN)
    !(|req) |=> !irqOut);

  // R6: the remembered level trails the synchronised level by one cycle
  a_r6_prev_tracks: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (prevLvl == $past(syncLvl)));

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic                 irqOut
);
  strobe_t strb;
  status_t stat;

  eic_ctrl #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .stat     (stat),
    .strb     (strb),
    .busRdata (busRdata)
  );

  eic_datapath #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .irqLines (irqLines),
    .strb     (strb),
    .stat     (stat),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // vector: {mode[5:0], 1'b0, initLevel, finalLevel, expectDetect}
  localparam logic [9:0] VEC [NV] = '{
    10'h015, 10'h016, 10'h023, 10'h020, 10'h045, 10'h042, 10'h083,
    10'h084, 10'h0C3, 10'h0C5, 10'h002, 10'h032, 10'h104 };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqLines = '0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  ext_irq_ctrl uut (.clk(clk), .rstN(rstN), .irqLines(irqLines), .busAddr(busAddr),
                    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    logic [31:0] v;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    rd(12'h000, v); check("R1 req", v, 0);
    rd(12'h004, v); check("R1 enable", v, 0);
    rd(12'h100, v); check("R1 detect", v, 0);
    rd(12'h180, v); check("R1 cfg0", v, 0);
    check("R1 irqOut", 32'(irqOut), 0);

    // sense-mode table, line k for vector k, enables all zero
    for (int k = 0; k < NV; k++) begin
      logic [5:0] mode;
      string tag;
      mode = VEC[k][9:4];
      tag = (mode == 6'h01 || mode == 6'h02) ? "R5 level" :
            (mode == 6'h04 || mode == 6'h08 || mode == 6'h0C) ? "R6 edge" : "R7 off";
      irqLines[k] = VEC[k][2];
      tick(4);
      wr(12'h180 + 12'(4*k), 32'(mode));
      wr(12'h100, 32'(1) << k);
      irqLines[k] = VEC[k][1];
      tick(4);
      rd(12'h100, v);
      check(tag, 32'(v[k]), 32'(VEC[k][0]));
    end
    // R10 masking: latches set but nothing enabled
    rd(12'h000, v); check("R10 masked req", v, 0);
    check("R10 masked irqOut", 32'(irqOut), 0);

    // R2 / R3 enables
    wr(12'h008, 32'h5);        rd(12'h004, v); check("R2 set", v, 32'h5);
    wr(12'h008, 32'h0);        rd(12'h004, v); check("R2 zero no effect", v, 32'h5);
    wr(12'h004, 32'h1);        rd(12'h004, v); check("R3 clear", v, 32'h4);
    wr(12'h004, 32'h0);        rd(12'h004, v); check("R3 zero no effect", v, 32'h4);
    wr(12'h004, 32'hFFFFFFFF); rd(12'h004, v); check("R3 clear all", v, 32'h0);

    // R4 config field width and misaligned access
    wr(12'h18C, 32'hFFFFFFFF); rd(12'h18C, v); check("R4 six bits", v, 32'h3F);
    wr(12'h18D, 32'h00000000); rd(12'h18C, v); check("R4 misaligned ignored", v, 32'h3F);

    // R5 level re-sets through a clear, R8 clear once inactive
    wr(12'h180 + 12'(4*20), 32'h02);
    irqLines[20] = 1'b1; tick(4);
    wr(12'h100, 32'(1) << 20);
    rd(12'h100, v); check("R5 level holds across clear", 32'(v[20]), 1);
    irqLines[20] = 1'b0; tick(4);
    wr(12'h100, 32'(1) << 20);
    rd(12'h100, v); check("R8 clear", 32'(v[20]), 0);

    // R6 edge stays clear while level stays high; R8 zero write no effect
    wr(12'h180 + 12'(4*21), 32'h08);
    irqLines[21] = 1'b1; tick(4);
    wr(12'h100, 32'h0);
    rd(12'h100, v); check("R8 zero no effect", 32'(v[21]), 1);
    wr(12'h100, 32'(1) << 21);
    tick(3);
    rd(12'h100, v); check("R6 no re-set", 32'(v[21]), 0);

    // R9 monitor after two synchroniser flops
    irqLines[31:28] = 4'b1010;
    tick(2);
    rd(12'h104, v); check("R9 monitor", v & 32'hF0000000, 32'hA0000000);

    // R10 request status and registered output
    wr(12'h180 + 12'(4*22), 32'h02);
    irqLines[22] = 1'b1; tick(4);
    wr(12'h008, 32'(1) << 22);
    rd(12'h000, v); check("R10 req", v, 32'(1) << 22);
    check("R10 irq lags", 32'(irqOut), 0);
    tick(1);
    check("R10 irq set", 32'(irqOut), 1);
    wr(12'h004, 32'(1) << 22);
    rd(12'h000, v); check("R10 req off", v, 0);
    check("R10 irq held", 32'(irqOut), 1);
    tick(1);
    check("R10 irq clear", 32'(irqOut), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule